// File: doc/BRIEF.md
# Bus Target Transaction Controller

This block is the target-side control engine of a 32-bit multiplexed address/data bus of the PCI kind, running on the bus clock. It samples the cycle-framing and initiator-ready strobes together with the shared address/data lines and the command/byte-enable lines. From those it recognises an address phase, latches the address and command, and decides whether the access belongs to it. For accesses it owns, it drives the registered device-select, target-ready and stop strobes together with their output enables.

A claimed access may be a single data phase or a burst, either reading or writing. Each completed data phase moves the local address on by one 32-bit word. A burst that would run past the top of the owned window is ended by a target disconnect. Accesses that belong to another agent are tracked in a busy state, where every pattern on the shared lines is ignored until the bus is idle again. Framing and initiator-ready enter the next-state logic directly, with no register in between, so leaving idle, seeing the last data phase and leaving the disconnect state cost no extra clock. User logic connects through a ready input, a per-phase transfer strobe, the current word address and a direction flag.

Top module: `bus_target_ctl`

## Requirements
- R1: While reset is asserted and right after it, device-select, target-ready and stop are high and all three output enables are low.
- R2: An address phase is recognised from idle only when framing is sampled low while initiator-ready is sampled high. Framing low together with initiator-ready low never starts a decode or a claim.
- R3: An access is claimed only when the latched command is 4'b0110 (memory read) or 4'b0111 (memory write) on cbe_n, and when address bits [31:WIN_BITS] equal those of BASE_ADDR. Every other access leaves all three strobes undriven.
- R4: For a claimed access, device-select goes low and all enables go high on the second rising edge after the address-phase edge. Target-ready stays high in that cycle.
- R5: After a miss, the block ignores all traffic, including patterns that look like a new address phase that hits, until framing and initiator-ready are both sampled high. After that it can claim again.
- R6: Target-ready is asserted on the edge after usr_rdy is sampled high, and not before. Once asserted it stays low until the data phase completes.
- R7: A data phase completes on an edge where initiator-ready and target-ready are both low. In that cycle usr_xfer is high and usr_addr equals the start address plus 4 times the phase index. Back-to-back phases run one per clock while usr_rdy stays high.
- R8: When framing is high at a completing phase, device-select and target-ready go high on that edge. The enables stay high for exactly one more cycle and then drop.
- R9: When the phase on the last word of the window (address bits [WIN_BITS-1:2] all ones) completes with framing still low, stop goes low, target-ready goes high and device-select stays low.
- R10: While stop is asserted, stop and device-select stay low for as long as framing is low. On the edge that samples framing high, both go high. The enables follow one cycle later.
- R11: Reads and writes both run as bursts, and usr_write reflects bit 0 of the latched command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Cycle-framing strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| ad_in | input | ADDR_W | Shared address/data lines as sampled |
| cbe_n | input | 4 | Command / byte-enable lines |
| usr_rdy | input | 1 | User side has read data ready or write space free |
| devsel_n | output | 1 | Device-select, registered, active low |
| devsel_oe | output | 1 | Drive enable for device-select |
| trdy_n | output | 1 | Target-ready, registered, active low |
| trdy_oe | output | 1 | Drive enable for target-ready |
| stop_n | output | 1 | Stop request, registered, active low |
| stop_oe | output | 1 | Drive enable for stop |
| usr_xfer | output | 1 | A data phase completes on the coming edge |
| usr_addr | output | ADDR_W | Word address of the current data phase |
| usr_write | output | 1 | High for a write access |

## Verification
Every start word in a 16-word window is combined with burst lengths from 1 to 4 and with several user-ready delays. This separates plain completion from the disconnect at the window top, and shows the address stepping and the target-ready gating. All sixteen command codes are tried at an address inside the window, and addresses just below, just above and far from the window are tried as well, so command decode and address decode are each checked on their own. Two stress patterns follow: a foreign access whose data phases copy a hitting address phase, and a bus caught mid-transfer with framing and initiator-ready both low. They tell the busy state and the strict address-phase condition apart from a decoder that looks at framing alone.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_BUSY,
    ST_XFER,
    ST_BACKOFF,
    ST_TURN
  } bt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/bt_hit_decode.sv
module bt_hit_decode
  import bt_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              WIN_BITS  = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  output logic              hit
);
  logic cmd_ok;
  logic win_ok;

  always_comb begin
    cmd_ok = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    win_ok = (addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
    hit    = cmd_ok && win_ok;
  end
endmodule

// File: rtl/bt_addr_track.sv
module bt_addr_track #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [3:0]        cbe_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [3:0]        cmd_q,
  output logic              last_dw
);
  localparam int IDX_W = WIN_BITS - 2;

  logic [ADDR_W-1:0] addr_d;
  logic [3:0]        cmd_d;
  logic              en;

  always_comb begin
    addr_d = addr_q;
    cmd_d  = cmd_q;
    en     = load || step;
    if (load) begin
      addr_d = ad_in;
      cmd_d  = cbe_n;
    end else if (step) begin
      addr_d[WIN_BITS-1:2] = addr_q[WIN_BITS-1:2] + 1'b1;
    end
    last_dw = &addr_q[WIN_BITS-1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      cmd_q  <= cmd_d;
    end
  end

  // R7: each completed phase moves the word index by one, upper bits kept
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q[WIN_BITS-1:2] == IDX_W'($past(addr_q[WIN_BITS-1:2]) + 1'b1))
                        && $stable(addr_q[ADDR_W-1:WIN_BITS]));
endmodule

// File: rtl/bus_target_ctl.sv
module bus_target_ctl
  import bt_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              WIN_BITS  = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [3:0]        cbe_n,
  input  logic              usr_rdy,
  output logic              devsel_n,
  output logic              devsel_oe,
  output logic              trdy_n,
  output logic              trdy_oe,
  output logic              stop_n,
  output logic              stop_oe,
  output logic              usr_xfer,
  output logic [ADDR_W-1:0] usr_addr,
  output logic              usr_write
);
  bt_state_e st_q, st_d;
  logic devsel_q, devsel_d;
  logic trdy_q, trdy_d;
  logic stop_q, stop_d;
  logic drive_q, drive_d;

  logic              addr_phase;
  logic              data_done;
  logic              load;
  logic              hit;
  logic              last_dw;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;

  // Unregistered bus qualifiers
  always_comb begin
    addr_phase = !frame_n && irdy_n;
    data_done  = (st_q == ST_XFER) && !irdy_n && !trdy_q;
    load       = ((st_q == ST_IDLE) || (st_q == ST_TURN)) && addr_phase;
  end

  bt_addr_track #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (data_done),
    .ad_in   (ad_in),
    .cbe_n   (cbe_n),
    .addr_q  (addr_q),
    .cmd_q   (cmd_q),
    .last_dw (last_dw)
  );

  bt_hit_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .addr (addr_q),
    .cmd  (cmd_q),
    .hit  (hit)
  );

  // Next-state and next-output logic
  always_comb begin
    st_d     = st_q;
    devsel_d = devsel_q;
    trdy_d   = trdy_q;
    stop_d   = stop_q;
    unique case (st_q)
      ST_IDLE: begin
        if (addr_phase) st_d = ST_DECODE;
      end
      ST_DECODE: begin
        if (hit) begin
          st_d     = ST_XFER;
          devsel_d = 1'b0;
          trdy_d   = 1'b1;
          stop_d   = 1'b1;
        end else begin
          st_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (frame_n && irdy_n) st_d = ST_IDLE;
      end
      ST_XFER: begin
        if (data_done) begin
          if (frame_n) begin
            st_d     = ST_TURN;
            devsel_d = 1'b1;
            trdy_d   = 1'b1;
          end else if (last_dw) begin
            st_d   = ST_BACKOFF;
            stop_d = 1'b0;
            trdy_d = 1'b1;
          end else begin
            trdy_d = !usr_rdy;
          end
        end else if (frame_n && irdy_n) begin
          st_d     = ST_TURN;
          devsel_d = 1'b1;
          trdy_d   = 1'b1;
        end else if (trdy_q && usr_rdy) begin
          trdy_d = 1'b0;
        end
      end
      ST_BACKOFF: begin
        if (frame_n) begin
          st_d     = ST_TURN;
          devsel_d = 1'b1;
          stop_d   = 1'b1;
        end
      end
      ST_TURN: begin
        st_d = addr_phase ? ST_DECODE : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    drive_d = (st_d == ST_XFER) || (st_d == ST_BACKOFF) || (st_d == ST_TURN);
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      devsel_q <= 1'b1;
      trdy_q   <= 1'b1;
      stop_q   <= 1'b1;
      drive_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      devsel_q <= devsel_d;
      trdy_q   <= trdy_d;
      stop_q   <= stop_d;
      drive_q  <= drive_d;
    end
  end

  always_comb begin
    devsel_n  = devsel_q;
    trdy_n    = trdy_q;
    stop_n    = stop_q;
    devsel_oe = drive_q;
    trdy_oe   = drive_q;
    stop_oe   = drive_q;
    usr_xfer  = data_done;
    usr_addr  = addr_q;
    usr_write = cmd_q[0];
  end

  // R2: a mid-transfer pattern seen in idle does not leave idle
  p_no_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !frame_n && !irdy_n) |=> (st_q == ST_IDLE));

  // R3: select only falls after a decode that hit
  p_claim_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_q) |-> ($past(st_q) == ST_DECODE) && $past(hit));

  // R5: busy state never drives the bus
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |-> (devsel_q && !drive_q));

  // R6: target-ready only follows a sampled user ready
  p_trdy_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_q) |-> $past(usr_rdy));

  // R8: enable still on in the cycle select returns high
  p_oe_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_q) |-> drive_q);

  // R10: framing high in backoff releases stop and select at once
  p_backoff_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BACKOFF && frame_n) |=> (stop_q && devsel_q));

  // R1: strobes are only low while driven
  p_low_when_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_q || !trdy_q || !stop_q) |-> drive_q);
endmodule

// File: tb/test_bus_target_ctl.sv
`timescale 1ns/1ps
module test_bus_target_ctl;
  localparam int          AW    = 32;
  localparam int          WB    = 6;
  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam int          DW    = 2 ** (WB - 2);

  logic clk = 1'b0;
  logic rst_n;
  logic frame_n, irdy_n, usr_rdy;
  logic [AW-1:0] ad_in;
  logic [3:0] cbe_n;
  logic devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe, usr_xfer, usr_write;
  logic [AW-1:0] usr_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bus_target_ctl #(.ADDR_W(AW), .WIN_BITS(WB), .BASE_ADDR(BASE)) i_bus_target_ctl (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .usr_rdy(usr_rdy), .devsel_n(devsel_n), .devsel_oe(devsel_oe),
    .trdy_n(trdy_n), .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe),
    .usr_xfer(usr_xfer), .usr_addr(usr_addr), .usr_write(usr_write)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
  endtask

  task automatic quiet(input string req);
    chk(req, {devsel_n, trdy_n, stop_n}, 3'b111);
    chk(req, {devsel_oe, trdy_oe, stop_oe}, 3'b000);
  endtask

  // One access: address a, command c, n data phases, w extra cycles of user not-ready
  task automatic run_txn(input logic [31:0] a, input logic [3:0] c, input int n, input int w);
    bit hit;
    int room;
    bit done;
    hit  = (a[31:WB] == BASE[31:WB]) && (c == 4'b0110 || c == 4'b0111);
    room = DW - int'(a[WB-1:2]);
    done = 1'b0;
    usr_rdy = 1'b0;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = c;
    step();
    quiet("R4 decode cycle");
    ad_in = ~a; cbe_n = 4'h0; irdy_n = 1'b0; frame_n = (n == 1);
    step();
    if (!hit) begin
      quiet("R3 miss not claimed");
      frame_n = 1'b1;
      step();
      quiet("R3 miss last phase");
      bus_idle();
      step();
      quiet("R3 miss idle");
      return;
    end
    chk("R4 select low", devsel_n, 1'b0);
    chk("R4 ready high", trdy_n, 1'b1);
    chk("R4 enables", {devsel_oe, trdy_oe, stop_oe, stop_n}, 4'b1111);
    for (int k = 0; k < w; k++) begin
      step();
      chk("R6 ready held off", trdy_n, 1'b1);
    end
    usr_rdy = 1'b1;
    step();
    chk("R6 ready follows user", trdy_n, 1'b0);
    for (int p = 0; p < n && !done; p++) begin
      frame_n = (p == n - 1);
      chk("R7 transfer strobe", usr_xfer, 1'b1);
      chk("R7 phase address", usr_addr, a + 32'(4 * p));
      chk("R11 direction", usr_write, c[0]);
      step();
      if (p == n - 1) begin
        chk("R8 release", {devsel_n, trdy_n, stop_n}, 3'b111);
        chk("R8 enable tail", devsel_oe, 1'b1);
        bus_idle();
        step();
        chk("R8 enable off", {devsel_oe, trdy_oe, stop_oe}, 3'b000);
        done = 1'b1;
      end else if (p == room - 1) begin
        chk("R9 disconnect", {devsel_n, trdy_n, stop_n}, 3'b010);
        for (int h = 0; h < 2; h++) begin
          step();
          chk("R10 stop held", {devsel_n, stop_n}, 2'b00);
        end
        frame_n = 1'b1;
        step();
        chk("R10 stop released", {devsel_n, stop_n}, 2'b11);
        chk("R10 enable tail", stop_oe, 1'b1);
        bus_idle();
        step();
        chk("R10 enable off", {devsel_oe, trdy_oe, stop_oe}, 3'b000);
        done = 1'b1;
      end else begin
        chk("R7 back to back", trdy_n, 1'b0);
      end
    end
    usr_rdy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    usr_rdy = 1'b0;
    bus_idle();
    @(negedge clk);
    quiet("R1 in reset");
    step();
    rst_n = 1'b1;
    step();
    quiet("R1 after reset");

    // Window sweep: every start word, burst lengths 1..4
    for (int off = 0; off < DW; off++)
      for (int n = 1; n <= 4; n++)
        run_txn(BASE + 32'(off * 4), ((off + n) % 2) ? 4'b0111 : 4'b0110, n, off % 3);

    // Command sweep inside the window
    for (int c = 0; c < 16; c++)
      run_txn(BASE + 32'h8, 4'(c), 2, 0);

    // Address boundaries
    run_txn(BASE - 32'h4, 4'b0110, 2, 0);
    run_txn(BASE + 32'(DW * 4), 4'b0111, 2, 0);
    run_txn(BASE ^ 32'h8000_0000, 4'b0110, 1, 0);
    run_txn(BASE + 32'(DW * 4 - 4), 4'b0110, 1, 1);

    // R5: foreign access whose waits copy a hitting address phase
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = BASE + 32'h100; cbe_n = 4'b0111;
    step();
    ad_in = BASE; cbe_n = 4'b0110;
    for (int k = 0; k < 3; k++) begin
      step();
      quiet("R5 foreign wait ignored");
    end
    irdy_n = 1'b0; frame_n = 1'b1;
    step();
    quiet("R5 foreign last phase");
    bus_idle();
    step();
    quiet("R5 back to idle");
    run_txn(BASE + 32'h4, 4'b0111, 3, 0);

    // R2: bus caught mid-transfer, framing and initiator-ready both low
    frame_n = 1'b0; irdy_n = 1'b0; ad_in = BASE; cbe_n = 4'b0110;
    usr_rdy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      quiet("R2 no address phase");
    end
    frame_n = 1'b1;
    step();
    step();
    quiet("R2 still quiet");
    bus_idle();
    step();
    usr_rdy = 1'b0;
    run_txn(BASE, 4'b0110, 4, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-wide actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule